// File: doc/BRIEF.md
# Primary-CPU Address Router with Programmable Tightly-Coupled Windows

This block decides, for every access issued by the main processor of a two-processor system, which memory or register target the access belongs to. It receives a 32-bit byte address, an access width and a write flag. It returns a target code and the offset of the access inside that target. The memory arrays, the I/O register contents and the logic that programs the tightly-coupled memory (TCM) windows all sit outside this block.

Two TCM windows are programmable at run time and are checked before the fixed region map. The instruction window starts at address zero and has a programmable length. The data window has a programmable base and length. A read-only boot ROM page at the top of the address space outranks both windows, but only for reads.

An access that reaches no target reads as zero. If such an access is a write, it is dropped and an error pulse is raised one cycle later. The decode outputs are combinational from the address and the current window registers. The window registers change only on a one-cycle configuration strobe.

Top module: `cpu_addr_router`

## Requirements
- R1: After reset the instruction window length is 0, the data window base is all ones and its length is 0, so no address selects either TCM until a configuration load.
- R2: A read whose address bits 31:12 equal 0xFFFF0 selects the boot ROM (target code 1) with offset equal to address bits 11:0. This outranks both TCM windows.
- R3: A write is never accepted by the boot ROM page. A write there is decoded by the lower-priority stages, and if none of them matches it is unmapped.
- R4: An address below the instruction window length selects the instruction TCM (code 2) with offset equal to address AND 0x7FFF. This outranks the data window and the fixed map.
- R5: An address at or above the data base and below base plus length selects the data TCM (code 3) with offset equal to (address − base) AND 0x3FFF. The upper bound is computed in 33 bits, so it never wraps, and the data TCM outranks the fixed map.
- R6: Otherwise, address bits 31:24 equal to 0x02 select main RAM (code 4) with offset equal to address AND 0x3FFFFF.
- R7: The I/O target (code 5, offset 0x180) is selected only by a halfword access (size code 1) to address 0x04000180. Any other access with address bits 31:24 equal to 0x04 is unmapped. Size codes are 0 for byte, 1 for halfword and 2 for word.
- R8: A one-cycle configuration strobe loads the instruction length, data base and data length together. The new values govern decoding from the next cycle on.
- R9: An unmapped access gives target code 0 and offset 0. A valid unmapped read raises the zero-data flag in the same cycle.
- R10: A valid unmapped write raises the write-error output for exactly the following cycle. Mapped accesses, reads and invalid cycles raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Byte address |
| cfg_load | input | 1 | Load strobe for the window registers |
| cfg_itcm_len | input | 32 | New instruction window length |
| cfg_dtcm_base | input | 32 | New data window base |
| cfg_dtcm_len | input | 32 | New data window length |
| sel_target | output | 3 | 0 none, 1 ROM, 2 ITCM, 3 DTCM, 4 main RAM, 5 I/O |
| sel_offset | output | 22 | Offset inside the selected target |
| rd_zero | output | 1 | Valid unmapped read: return zero data |
| wr_err | output | 1 | One-cycle pulse after a valid unmapped write |

## Verification
The checker confirms on every cycle the properties that hold for a single access. Writes never land in the ROM, and ROM reads get the correct page offset. The TCM and I/O selections stay within their offset ranges and size rule. No TCM hit is possible before the first configuration load, and the error pulse follows a dropped write by exactly one cycle. Some cases depend on register values and on how the stages are ordered. These are the priority conflicts between overlapping windows, the mirroring of offsets, the 33-bit upper bound near the top of memory, and the one-cycle delay before a new configuration takes effect. Only the bench scenarios, compared each cycle against the behavioural model, show these.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_ITCM = 3'd2,
        TGT_DTCM = 3'd3,
        TGT_MAIN = 3'd4,
        TGT_IO   = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam int          ADDR_W     = 32;
    localparam int          OFS_W      = 22;
    localparam int          ROM_OFS_W  = 12;
    localparam int          ITCM_OFS_W = 15;
    localparam int          DTCM_OFS_W = 14;
    localparam int          MAIN_OFS_W = 22;
    localparam logic [19:0] ROM_PAGE   = 20'hFFFF0;
    localparam logic [7:0]  MAIN_TAG   = 8'h02;
    localparam logic [7:0]  IO_TAG     = 8'h04;
    localparam logic [31:0] SYNC_ADDR  = 32'h0400_0180;

    typedef struct packed {
        logic             hit;
        logic [OFS_W-1:0] ofs;
    } match_t;

endpackage

// File: rtl/addr_router_cfg.sv
module addr_router_cfg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] itcm_len_in,
    input  logic [AW-1:0] dtcm_base_in,
    input  logic [AW-1:0] dtcm_len_in,
    output logic [AW-1:0] itcm_len,
    output logic [AW-1:0] dtcm_base,
    output logic [AW-1:0] dtcm_len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            itcm_len  <= '0;
            dtcm_base <= '1;
            dtcm_len  <= '0;
        end else if (load) begin
            itcm_len  <= itcm_len_in;
            dtcm_base <= dtcm_base_in;
            dtcm_len  <= dtcm_len_in;
        end
    end
endmodule

// File: rtl/addr_router_tcm_match.sv
module addr_router_tcm_match
    import addr_router_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = ITCM_OFS_W,
    parameter int DW = DTCM_OFS_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] itcm_len,
    input  logic [AW-1:0] dtcm_base,
    input  logic [AW-1:0] dtcm_len,
    output match_t        itcm_m,
    output match_t        dtcm_m
);
    localparam logic [AW-1:0] IMASK = {{(AW-IW){1'b0}}, {IW{1'b1}}};
    localparam logic [AW-1:0] DMASK = {{(AW-DW){1'b0}}, {DW{1'b1}}};

    logic [AW:0]   dtcm_end;
    logic [AW-1:0] dtcm_rel;

    always_comb begin
        dtcm_end   = {1'b0, dtcm_base} + {1'b0, dtcm_len};
        dtcm_rel   = addr - dtcm_base;
        itcm_m.hit = addr < itcm_len;
        itcm_m.ofs = OFS_W'(addr & IMASK);
        dtcm_m.hit = (addr >= dtcm_base) && ({1'b0, addr} < dtcm_end);
        dtcm_m.ofs = OFS_W'(dtcm_rel & DMASK);
    end
endmodule

// File: rtl/addr_router_fixed_map.sv
module addr_router_fixed_map
    import addr_router_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output match_t        rom_m,
    output match_t        main_m,
    output match_t        io_m
);
    localparam logic [AW-1:0] MMASK = {{(AW-MAIN_OFS_W){1'b0}}, {MAIN_OFS_W{1'b1}}};

    logic [7:0] top_byte;

    always_comb begin
        top_byte   = addr[AW-1:AW-8];
        rom_m.hit  = addr[AW-1:ROM_OFS_W] == (AW-ROM_OFS_W)'(ROM_PAGE);
        rom_m.ofs  = OFS_W'(addr[ROM_OFS_W-1:0]);
        main_m.hit = top_byte == MAIN_TAG;
        main_m.ofs = OFS_W'(addr & MMASK);
        io_m.hit   = (top_byte == IO_TAG) && (addr == AW'(SYNC_ADDR))
                     && (size == SZ_HALF);
        io_m.ofs   = OFS_W'(addr[ROM_OFS_W-1:0]);
    end
endmodule

// File: rtl/cpu_addr_router.sv
module cpu_addr_router
    import addr_router_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_itcm_len,
    input  logic [AW-1:0] cfg_dtcm_base,
    input  logic [AW-1:0] cfg_dtcm_len,
    output logic [2:0]    sel_target,
    output logic [OW-1:0] sel_offset,
    output logic          rd_zero,
    output logic          wr_err
);
    logic [AW-1:0] itcm_len, dtcm_base, dtcm_len;
    match_t        itcm_m, dtcm_m, rom_m, main_m, io_m;
    tgt_e          tgt;
    logic [OFS_W-1:0] ofs;

    addr_router_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst(rst), .load(cfg_load),
        .itcm_len_in(cfg_itcm_len), .dtcm_base_in(cfg_dtcm_base),
        .dtcm_len_in(cfg_dtcm_len),
        .itcm_len(itcm_len), .dtcm_base(dtcm_base), .dtcm_len(dtcm_len)
    );

    addr_router_tcm_match #(.AW(AW)) u_tcm (
        .addr(acc_addr), .itcm_len(itcm_len), .dtcm_base(dtcm_base),
        .dtcm_len(dtcm_len), .itcm_m(itcm_m), .dtcm_m(dtcm_m)
    );

    addr_router_fixed_map #(.AW(AW)) u_map (
        .addr(acc_addr), .size(acc_size),
        .rom_m(rom_m), .main_m(main_m), .io_m(io_m)
    );

    // Priority chain: ROM (reads only), ITCM, DTCM, then fixed regions
    always_comb begin
        tgt = TGT_NONE;
        ofs = '0;
        if (rom_m.hit && !acc_write) begin
            tgt = TGT_ROM;  ofs = rom_m.ofs;
        end else if (itcm_m.hit) begin
            tgt = TGT_ITCM; ofs = itcm_m.ofs;
        end else if (dtcm_m.hit) begin
            tgt = TGT_DTCM; ofs = dtcm_m.ofs;
        end else if (main_m.hit) begin
            tgt = TGT_MAIN; ofs = main_m.ofs;
        end else if (io_m.hit) begin
            tgt = TGT_IO;   ofs = io_m.ofs;
        end
    end

    assign sel_target = tgt;
    assign sel_offset = OW'(ofs);
    assign rd_zero    = acc_valid && !acc_write && (tgt == TGT_NONE);

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= acc_valid && acc_write && (tgt == TGT_NONE);
    end
endmodule

// File: rtl/addr_router_chk.sv
module addr_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  acc_size,
    input logic [31:0] acc_addr,
    input logic        cfg_load,
    input logic [2:0]  sel_target,
    input logic [21:0] sel_offset,
    input logic        rd_zero,
    input logic        wr_err
);
    logic seen_cfg;
    always_ff @(posedge clk) begin
        if (rst)           seen_cfg <= 1'b0;
        else if (cfg_load) seen_cfg <= 1'b1;
    end

    assert_tcm_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_cfg |-> (sel_target != 3'd2 && sel_target != 3'd3));

    assert_rom_read_R2: assert property (@(posedge clk) disable iff (rst)
        (!acc_write && acc_addr[31:12] == 20'hFFFF0)
        |-> (sel_target == 3'd1 && sel_offset == {10'd0, acc_addr[11:0]}));

    assert_rom_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        acc_write |-> sel_target != 3'd1);

    assert_itcm_offset_R4: assert property (@(posedge clk) disable iff (rst)
        sel_target == 3'd2 |-> sel_offset == {7'd0, acc_addr[14:0]});

    assert_dtcm_range_R5: assert property (@(posedge clk) disable iff (rst)
        sel_target == 3'd3 |-> sel_offset[21:14] == 8'd0);

    assert_main_tag_R6: assert property (@(posedge clk) disable iff (rst)
        sel_target == 3'd4 |-> acc_addr[31:24] == 8'h02);

    assert_io_exact_R7: assert property (@(posedge clk) disable iff (rst)
        sel_target == 3'd5 |-> (acc_size == 2'd1 && acc_addr == 32'h0400_0180));

    assert_zero_read_R9: assert property (@(posedge clk) disable iff (rst)
        rd_zero |-> (sel_target == 3'd0 && sel_offset == 22'd0 && !acc_write));

    assert_err_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && sel_target == 3'd0) |=> wr_err);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(acc_valid && acc_write && sel_target == 3'd0));
endmodule

bind cpu_addr_router addr_router_chk i_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .cfg_load(cfg_load),
    .sel_target(sel_target), .sel_offset(sel_offset),
    .rd_zero(rd_zero), .wr_err(wr_err)
);

// File: tb/test_cpu_addr_router.sv
module test_cpu_addr_router;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0, cfg_load = 1'b0;
    logic [1:0]  acc_size = 2'd2;
    logic [31:0] acc_addr = '0, cfg_itcm_len = '0, cfg_dtcm_base = '0, cfg_dtcm_len = '0;
    logic [2:0]  sel_target;
    logic [21:0] sel_offset;
    logic        rd_zero, wr_err;

    int n_vec = 0, n_bad = 0;

    // behavioural model state
    longint m_ilen = 0, m_dbase = 32'hFFFF_FFFF, m_dlen = 0;
    bit     m_err = 0;

    always #(PERIOD/2) clk = ~clk;

    cpu_addr_router i_cpu_addr_router (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_addr(acc_addr), .cfg_load(cfg_load),
        .cfg_itcm_len(cfg_itcm_len), .cfg_dtcm_base(cfg_dtcm_base),
        .cfg_dtcm_len(cfg_dtcm_len), .sel_target(sel_target),
        .sel_offset(sel_offset), .rd_zero(rd_zero), .wr_err(wr_err)
    );

    task automatic expect_eq(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ref_decode(input longint a, input bit wr, input int sz,
                              output int t, output longint o);
        t = 0; o = 0;
        if (!wr && (a >> 12) == 'hFFFF0)            begin t = 1; o = a % 4096; end
        else if (a < m_ilen)                        begin t = 2; o = a % 32768; end
        else if (a >= m_dbase && a < m_dbase + m_dlen) begin t = 3; o = (a - m_dbase) % 16384; end
        else if ((a >> 24) == 2)                    begin t = 4; o = a % (1 << 22); end
        else if (a == 'h0400_0180 && sz == 1)       begin t = 5; o = 'h180; end
    endtask

    task automatic step(string req, bit v, bit wr, int sz, longint a,
                        bit ld = 0, longint il = 0, longint db = 0, longint dl = 0);
        int t; longint o;
        @(negedge clk);
        acc_valid = v; acc_write = wr; acc_size = 2'(sz); acc_addr = 32'(a);
        cfg_load = ld; cfg_itcm_len = 32'(il); cfg_dtcm_base = 32'(db); cfg_dtcm_len = 32'(dl);
        #1;
        ref_decode(a, wr, sz, t, o);
        expect_eq(req, "target", sel_target, t);
        expect_eq(req, "offset", sel_offset, o);
        expect_eq(req, "rd_zero", rd_zero, v && !wr && t == 0);
        expect_eq(req, "wr_err", wr_err, m_err);
        m_err = v && wr && t == 0;
        if (ld) begin m_ilen = il; m_dbase = db; m_dlen = dl; end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset window state
        step("R1", 1, 0, 2, 'h0000_0000);
        step("R1", 1, 0, 2, 'hFFFF_FFFF);
        step("R1", 1, 1, 2, 'h0000_0100);
        // R2 ROM read, R3 ROM write rejected, R10 pulse
        step("R2", 1, 0, 2, 'hFFFF_0ABC);
        step("R3", 1, 1, 1, 'hFFFF_0010);
        step("R10", 1, 0, 2, 'h0212_3456);
        // R6 main RAM with mirroring
        step("R6", 1, 0, 0, 'h02FF_FFFC);
        step("R6", 1, 1, 2, 'h0200_0040);
        // R7 I/O register decode
        step("R7", 1, 0, 1, 'h0400_0180);
        step("R7", 1, 1, 1, 'h0400_0180);
        step("R7", 1, 0, 2, 'h0400_0180);
        step("R7", 1, 0, 1, 'h0400_0182);
        // R8 load takes effect next cycle
        step("R8", 1, 0, 2, 'h0000_1234, 1, 'h1_0000, 'h0080_0000, 'h4000);
        step("R8", 1, 0, 2, 'h0000_1234);
        step("R4", 1, 0, 2, 'h0000_A234);
        step("R5", 1, 0, 2, 'h0080_0010);
        step("R5", 1, 1, 0, 'h0080_3FFF);
        step("R5", 1, 0, 2, 'h0080_4000);
        // R4 over R5 and fixed map
        step("R4", 1, 0, 2, 'h0000_0000, 1, 'h0300_0000, 'h0200_0000, 'h1000);
        step("R4", 1, 0, 2, 'h0200_0010);
        step("R4", 1, 1, 2, 'h02FF_F000);
        // R5 over main RAM
        step("R5", 1, 0, 2, 'h0000_0000, 1, 0, 'h0200_0000, 'h1000);
        step("R5", 1, 0, 2, 'h0200_0800);
        step("R6", 1, 0, 2, 'h0200_1000);
        // R5 33-bit bound at top of memory, R2 priority, R3 fallthrough
        step("R5", 1, 0, 2, 'h0000_0000, 1, 0, 'hFFFF_0000, 'h1_0000);
        step("R2", 1, 0, 2, 'hFFFF_0004);
        step("R3", 1, 1, 2, 'hFFFF_0004);
        step("R5", 1, 0, 2, 'hFFFF_FFF0);
        step("R5", 1, 0, 2, 'h0000_0010);
        // R9/R10 unmapped write pulse, idle, invalid
        step("R10", 1, 1, 2, 'h0800_0000);
        step("R10", 0, 0, 2, 'h0000_0000);
        step("R10", 0, 0, 2, 'h0000_0000);
        step("R10", 0, 1, 2, 'h0800_0000);
        step("R9", 1, 0, 0, 'h0900_0000);
        step("R10", 1, 1, 2, 'h0800_0004);
        step("R10", 1, 1, 2, 'h0800_0008);
        step("R10", 1, 0, 2, 'h0200_0000);
        step("R10", 0, 0, 2, 'h0200_0000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule